// File: doc/BRIEF.md
# Weight-Stationary Systolic MAC Grid with Per-Cell Fault Bypass

This block is a square grid of multiply-accumulate cells for inference on quantized signed 8-bit data. Each cell keeps one weight. The weights are shifted in from the top edge, one grid row per load cycle. Activation vectors enter at the left edge. Internal delay lines skew them so that row r runs r cycles behind row 0. Partial sums move one row down per cycle, and the bottom edge produces one 32-bit column result per vector. A second set of delay lines realigns the column results so that a whole result vector appears on one cycle.

A fault mask register holds one bit per cell. A cell whose bit is set passes the partial sum from above straight through. Its weight is pruned in hardware, and the other cells in its row and column keep working. The mask keeps its value across any number of weight loads and compute passes until it is rewritten. A done pulse marks the last result of each run of consecutive vectors.

Top module: `wsg_grid`

## Requirements
- R1: Each cycle with `wt_load` high shifts every stored weight row down by one and places `wt_row` in grid row 0. After DIM load cycles, grid row r holds the row presented on load cycle DIM-1-r, so the first row presented ends up at the bottom. Stored weights do not change while `wt_load` is low, whatever `wt_row` carries.
- R2: For an accepted activation vector x, output lane c equals the signed sum over rows r of x[r]*W[r][c]. Operands are two's-complement 8-bit values and results are 32-bit signed. Activation lane r is `act_vec[r*DW +: DW]`, weight lane c is `wt_row[c*DW +: DW]`, and result lane c is `out_vec[c*AW +: AW]`.
- R3: A vector sampled with `act_valid` high at clock edge k appears on `out_vec` with `out_valid` high in the cycle that follows edge k+2*DIM-2. Vectors issued back to back come out one per cycle, in the order they were issued, and `out_valid` is never high without a matching input.
- R4: When mask bit r*DIM+c is set, cell (r,c) adds nothing, and every result equals the sum computed with W[r][c] set to zero. Contributions of unmasked cells are not affected.
- R5: The mask register takes `mask_in` on each cycle that `mask_we` is high. It keeps its value through weight loads and compute passes otherwise, and clearing it restores every contribution.
- R6: `done` is high for exactly one cycle, together with the `out_valid` of the last vector in a run of consecutively issued vectors, and it is low at all other times.
- R7: Reset clears the outputs, the mask and all stored weights. A vector issued right after reset therefore produces an all-zero result.
- R8: Extreme operands (-128 times -128, and 127 times -128, summed over all rows) give exact results with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_we | input | 1 | Write enable for the fault mask |
| mask_in | input | DIM*DIM | New mask value, bit r*DIM+c for cell (r,c) |
| wt_load | input | 1 | Shift one weight row into the grid |
| wt_row | input | DIM*DW | Weight row, lane c for column c |
| act_valid | input | 1 | Activation vector present |
| act_vec | input | DIM*DW | Activation vector, lane r for grid row r |
| out_valid | output | 1 | Result vector present |
| out_vec | output | DIM*AW | Result vector, lane c for column c |
| done | output | 1 | Last result of a run of consecutive vectors |

## Verification
The bench builds the grid with DIM=4, DW=8 and AW=32. This gives a full wavefront of 6 edges and deskew depths from 0 to 3, so every lane's skew path and every deskew path is exercised by back-to-back streams. With four rows, an extreme column sum reaches 65536, which a correct accumulator must hold exactly. Mask patterns hit one corner, a pair of cells in the same row, the diagonal and the full grid, and each pass is checked against a zero-pruned reference product.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

   localparam int WSG_MAX_DIM = 16;

   // accumulator bits that keep a dim-term sum of dw x dw signed products exact
   function automatic int wsg_acc_need(input int dw, input int dim);
      return 2 * dw + $clog2(dim);
   endfunction

endpackage

// File: rtl/wsg_delay.sv
module wsg_delay #(
   parameter int W = 8,
   parameter int D = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stg_q [D];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < D; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= din;
         for (int i = 1; i < D; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign dout = stg_q[D-1];

endmodule

// File: rtl/wsg_mac.sv
module wsg_mac #(
   parameter int DW = 8,
   parameter int AW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bypass,
   input  logic        [DW-1:0] a_in,
   input  logic        [DW-1:0] w_in,
   input  logic signed [AW-1:0] ps_in,
   output logic signed [AW-1:0] ps_out
);

   logic signed [2*DW-1:0] prod;

   assign prod = $signed(a_in) * $signed(w_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ps_out <= '0;
      else if (bypass) ps_out <= ps_in;
      else             ps_out <= ps_in + AW'(prod);
   end

endmodule

// File: rtl/wsg_grid.sv
module wsg_grid
   import wsg_pkg::*;
#(
   parameter int DIM = 4,
   parameter int DW  = 8,
   parameter int AW  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mask_we,
   input  logic [DIM*DIM-1:0]    mask_in,
   input  logic                  wt_load,
   input  logic [DIM*DW-1:0]     wt_row,
   input  logic                  act_valid,
   input  logic [DIM*DW-1:0]     act_vec,
   output logic                  out_valid,
   output logic [DIM*AW-1:0]     out_vec,
   output logic                  done
);

   localparam int NCELL = DIM * DIM;
   localparam int ROWB  = DIM * DW;
   localparam int VLAT  = 2 * DIM - 1;

   if (DIM < 2 || DIM > WSG_MAX_DIM) begin : g_bad_dim
      $error("wsg_grid: DIM out of supported range");
   end
   if (AW < wsg_acc_need(DW, DIM)) begin : g_bad_aw
      $error("wsg_grid: AW too narrow for exact column sums");
   end

   logic [NCELL-1:0]     mask_q;
   logic [NCELL*DW-1:0]  wgt_q;
   logic [VLAT-1:0]      vld_q;
   logic [DW-1:0]        act_w [DIM][DIM];
   logic signed [AW-1:0] ps_w  [DIM+1][DIM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_in;
   end

   // row 0 of the grid sits in the low bits; a load pushes every row one deeper
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wgt_q <= '0;
      else if (wt_load) wgt_q <= {wgt_q[NCELL*DW-ROWB-1:0], wt_row};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= {vld_q[VLAT-2:0], act_valid};
   end

   assign out_valid = vld_q[VLAT-1];
   assign done      = vld_q[VLAT-1] & ~vld_q[VLAT-2];

   for (genvar r = 0; r < DIM; r++) begin : g_row
      // input skew: row r lags row 0 by r cycles
      if (r == 0) begin : g_noskew
         assign act_w[0][0] = act_vec[DW-1:0];
      end else begin : g_skew
         wsg_delay #(.W(DW), .D(r)) u_skew (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (act_vec[r*DW +: DW]),
            .dout (act_w[r][0])
         );
      end

      for (genvar c = 0; c < DIM; c++) begin : g_col
         if (c < DIM - 1) begin : g_hop
            logic [DW-1:0] hop_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) hop_q <= '0;
               else        hop_q <= act_w[r][c];
            end
            assign act_w[r][c+1] = hop_q;
         end

         wsg_mac #(.DW(DW), .AW(AW)) u_mac (
            .clk   (clk),
            .rst_n (rst_n),
            .bypass(mask_q[r*DIM+c]),
            .a_in  (act_w[r][c]),
            .w_in  (wgt_q[(r*DIM+c)*DW +: DW]),
            .ps_in (ps_w[r][c]),
            .ps_out(ps_w[r+1][c])
         );
      end
   end

   for (genvar c = 0; c < DIM; c++) begin : g_out
      assign ps_w[0][c] = '0;
      // output deskew: column c waits DIM-1-c cycles so all lanes line up
      if (c == DIM - 1) begin : g_direct
         assign out_vec[c*AW +: AW] = ps_w[DIM][c];
      end else begin : g_deskew
         wsg_delay #(.W(AW), .D(DIM-1-c)) u_dsk (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ps_w[DIM][c]),
            .dout (out_vec[c*AW +: AW])
         );
      end
   end

endmodule

// File: rtl/wsg_grid_chk.sv
module wsg_grid_chk #(
   parameter int DIM = 4,
   parameter int DW  = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    mask_we,
   input logic [DIM*DIM-1:0]      mask_in,
   input logic [DIM*DIM-1:0]      mask_q,
   input logic                    wt_load,
   input logic [DIM*DIM*DW-1:0]   wgt_q,
   input logic                    act_valid,
   input logic                    out_valid,
   input logic                    done
);

   logic [15:0] inflight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight + 16'(act_valid) - 16'(out_valid);
   end

   AST_WGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wt_load |=> $stable(wgt_q)); // R1

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (inflight != 16'd0)); // R3

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask_q == $past(mask_in))); // R5

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q)); // R5

   AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> out_valid); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

endmodule

bind wsg_grid wsg_grid_chk #(.DIM(DIM), .DW(DW)) u_chk (.*);

// File: tb/wsg_grid_test.sv
`timescale 1ns/1ps
module wsg_grid_test;

   localparam int N    = 4;
   localparam int DW   = 8;
   localparam int AW   = 32;
   localparam int LATE = 2 * N - 2;
   localparam int NTAB = 6;

   // stimulus table: activation vector (lane r in byte r) and whether it closes a run
   localparam logic [N*DW-1:0] ACT_TAB [NTAB] = '{
      32'h04_03_02_01, 32'h10_7F_80_FF, 32'h00_00_00_00,
      32'h7F_7F_7F_7F, 32'hF6_0A_FB_05, 32'h01_80_01_80 };
   localparam bit RUN_END [NTAB] = '{0, 0, 1, 0, 0, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mask_we = 1'b0;
   logic [N*N-1:0] mask_in = '0;
   logic wt_load = 1'b0;
   logic [N*DW-1:0] wt_row = '0;
   logic act_valid = 1'b0;
   logic [N*DW-1:0] act_vec = '0;
   logic out_valid;
   logic [N*AW-1:0] out_vec;
   logic done;

   int wm [N][N];
   logic [N*N-1:0] msk_model = '0;
   logic [N*AW-1:0] exp_q [64];
   int  iss_cyc [64];
   bit  last_q [64];
   int  n_iss = 0, n_rd = 0, cyc = 0;
   int  checks = 0, fails = 0;
   bit  finished = 0;
   string cur_tag = "R7";

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc++;

   wsg_grid #(.DIM(N), .DW(DW), .AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_in(mask_in),
      .wt_load(wt_load), .wt_row(wt_row), .act_valid(act_valid), .act_vec(act_vec),
      .out_valid(out_valid), .out_vec(out_vec), .done(done));

   function automatic logic [N*AW-1:0] ref_mv(input logic [N*DW-1:0] av);
      logic [N*AW-1:0] res;
      for (int c = 0; c < N; c++) begin
         int s = 0;
         for (int r = 0; r < N; r++)
            if (!msk_model[r*N+c]) s += int'($signed(av[r*DW +: DW])) * wm[r][c];
         res[c*AW +: AW] = s;
      end
      return res;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [N*AW-1:0] act, input logic [N*AW-1:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic load_w();
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         wt_load = 1'b1;
         for (int c = 0; c < N; c++) wt_row[c*DW +: DW] = DW'(wm[N-1-i][c]);
      end
      @(negedge clk);
      wt_load = 1'b0;
      wt_row  = 32'hA5C3_5A3C;   // must be ignored (R1)
      repeat (3) @(negedge clk);
   endtask

   task automatic set_mask(input logic [N*N-1:0] m);
      @(negedge clk);
      mask_we = 1'b1;
      mask_in = m;
      @(negedge clk);
      mask_we = 1'b0;
      mask_in = ~m;              // must be ignored (R5)
      msk_model = m;
   endtask

   task automatic issue(input logic [N*DW-1:0] av, input bit last);
      @(negedge clk);
      act_valid = 1'b1;
      act_vec = av;
      exp_q[n_iss] = ref_mv(av);
      iss_cyc[n_iss] = cyc + 1;
      last_q[n_iss] = last;
      n_iss++;
      if (last) begin
         @(negedge clk);
         act_valid = 1'b0;
         act_vec = '1;
      end
   endtask

   task automatic drain();
      repeat (2 * N + 2) @(negedge clk);
      check(n_rd == n_iss, "R3 every issued vector came out", n_rd, n_iss);
   endtask

   // output monitor, sampling away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid) begin
            if (n_rd >= n_iss) begin
               check(1'b0, "R3 output without input", out_vec, '0);
            end else begin
               check(out_vec == exp_q[n_rd], {cur_tag, " result"}, out_vec, exp_q[n_rd]);
               check(cyc == iss_cyc[n_rd] + LATE, "R3 latency", cyc, iss_cyc[n_rd] + LATE);
               check(done == last_q[n_rd], "R6 done on last of run", done, last_q[n_rd]);
               n_rd++;
            end
         end else if (done) begin
            check(1'b0, "R6 done without output", done, 0);
         end
      end
   end

   initial begin
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) wm[r][c] = 0;

      // R7: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
      check(done == 1'b0, "R7 done in reset", done, 0);
      check(out_vec == '0, "R7 out_vec in reset", out_vec, '0);
      rst_n = 1'b1;
      cur_tag = "R7 zero weights after reset";
      issue(ACT_TAB[0], 1'b1);
      drain();

      // R1/R2/R3/R6: table walk with a dense weight matrix
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) wm[r][c] = r * 7 - c * 3 - 5;
      load_w();
      cur_tag = "R1/R2 product";
      for (int i = 0; i < NTAB; i++) issue(ACT_TAB[i], RUN_END[i]);
      drain();

      // R4: corner, same-row pair and diagonal cells bypassed
      set_mask(16'h8431);
      cur_tag = "R4 masked product";
      for (int i = 0; i < NTAB; i++) issue(ACT_TAB[i], RUN_END[i]);
      drain();

      // R5: mask survives a weight reload; a single-vector run checks done
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) wm[r][c] = c * 5 - r * 4 + 3;
      load_w();
      cur_tag = "R5 mask held across reload";
      issue(ACT_TAB[1], 1'b0);
      issue(ACT_TAB[4], 1'b1);
      issue(ACT_TAB[5], 1'b1);
      drain();
      set_mask('0);
      cur_tag = "R5 mask cleared";
      issue(ACT_TAB[1], 1'b1);
      drain();

      // R8: extremes
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) wm[r][c] = -128;
      load_w();
      cur_tag = "R8 extreme operands";
      issue({N{8'h80}}, 1'b0);
      issue({N{8'h7F}}, 1'b1);
      drain();

      // R4: whole grid bypassed gives zero
      set_mask('1);
      cur_tag = "R4 all cells bypassed";
      issue({N{8'h80}}, 1'b1);
      drain();

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule